// File: doc/BRIEF.md
# Fetch-Stage Branch Target Table

This block predicts where instruction fetch should go next. It is consulted with the fetch PC before the instruction has been decoded. If the table holds an entry whose stored address equals that PC and whose direction counter leans taken, the block returns the remembered target. The fetch unit registers that value and fetches from it on the following cycle. In every other case the block returns the sequential address, which is the fetch PC plus one instruction word.

The table is direct-mapped. Each slot holds a valid flag, the upper PC bits as a full tag, a full-width target address and a saturating direction counter. A second port receives resolved branches from the execute stage, giving the branch PC, its actual direction and its actual target. That port trains the counters, allocates entries for taken branches that missed, and raises a same-cycle mispredict flag that the pipeline's flush logic can use. A branch resolved not taken lowers its counter but keeps its entry.

Top module: `brtgt_table`

## Requirements
- R1: Reset clears every valid flag. After reset no fetch PC hits, `pred_taken` is 0 and `next_pc` is `fetch_pc + 4`.
- R2: With the default parameters the slot index is PC[7:2] and the tag is PC[31:8]. A hit needs the slot to be valid and its tag to equal PC[31:8]. A PC that shares the index but differs in the tag never hits. PC[1:0] take no part in the comparison.
- R3: On a hit whose counter is 2 or 3 (MSB set), `pred_taken` is 1 and `next_pc` equals the stored target, in the same cycle as the lookup.
- R4: On a miss, or on a hit whose counter is 0 or 1, `pred_taken` is 0 and `next_pc` is `fetch_pc + 4`. `pred_target` shows the stored target on a hit and 0 on a miss.
- R5: A taken resolution that misses writes its slot with valid=1, the resolved PC's tag, the resolved target and counter 2 (weakly taken). This replaces any previous occupant of that slot.
- R6: A not-taken resolution that misses changes nothing in the table.
- R7: A not-taken resolution that hits decrements the counter, which saturates at 0. The entry stays valid.
- R8: A taken resolution that hits increments the counter, which saturates at 3, and overwrites the stored target with the resolved target.
- R9: `mispredict` is combinational in the cycle `upd_valid` is high. It is 1 when the table's prediction for `upd_pc` (taken = hit with counter MSB set) differs from `upd_taken`. It is also 1 when both are taken but the stored target differs from `upd_target`. It is 0 whenever `upd_valid` is 0.
- R10: An update takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | PC of the instruction being fetched |
| upd_valid | input | 1 | A branch resolution is presented this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |
| hit | output | 1 | Valid entry with matching tag for `fetch_pc` |
| pred_taken | output | 1 | Hit and counter leans taken |
| pred_target | output | 32 | Stored target on a hit, else 0 |
| next_pc | output | 32 | Predicted next fetch address |
| mispredict | output | 1 | Resolution disagrees with the table's prediction |

## Verification
Lookup results and the mispredict flag are combinational, so they are due in the same cycle as their inputs. The bench drives inputs just after the falling edge and compares one time unit later, before the rising edge. Table changes are due one rising edge after the resolution. The reference model applies each update only after that cycle's comparison, so a lookup is checked against old contents in the update cycle and against new contents from the next cycle on.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

   localparam int unsigned CTR_MAX_W = 8;

   typedef enum logic [1:0] {
      UPD_IDLE  = 2'd0,
      UPD_ALLOC = 2'd1,
      UPD_TRAIN = 2'd2
   } upd_kind_e;

   // Saturating step of a direction counter held in the low bits of c.
   function automatic logic [CTR_MAX_W-1:0] ctr_step(
      input logic [CTR_MAX_W-1:0] c,
      input logic                 up,
      input logic [CTR_MAX_W-1:0] top);
      logic [CTR_MAX_W-1:0] r;
      if (up) r = (c == top) ? c : c + 1'b1;
      else    r = (c == '0)  ? c : c - 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/brtgt_slot.sv
module brtgt_slot #(
   parameter int unsigned TAG_W = 24,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned CTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt,
   input  logic [CTR_W-1:0] wr_ctr,
   output logic             vld,
   output logic [TAG_W-1:0] tag,
   output logic [PC_W-1:0]  tgt,
   output logic [CTR_W-1:0] ctr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         tag <= '0;
         tgt <= '0;
         ctr <= '0;
      end else if (wr_en) begin
         vld <= 1'b1;
         tag <= wr_tag;
         tgt <= wr_tgt;
         ctr <= wr_ctr;
      end
   end

endmodule

// File: rtl/brtgt_rdport.sv
module brtgt_rdport #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned TAG_W   = 24,
   parameter int unsigned PC_W    = 32,
   parameter int unsigned CTR_W   = 2
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] key,
   input  logic             vld_a [ENTRIES],
   input  logic [TAG_W-1:0] tag_a [ENTRIES],
   input  logic [PC_W-1:0]  tgt_a [ENTRIES],
   input  logic [CTR_W-1:0] ctr_a [ENTRIES],
   output logic             hit,
   output logic             lean_taken,
   output logic [PC_W-1:0]  tgt,
   output logic [CTR_W-1:0] ctr
);

   logic             sel_vld;
   logic [TAG_W-1:0] sel_tag;

   always_comb begin
      sel_vld = vld_a[idx];
      sel_tag = tag_a[idx];
      hit     = sel_vld && (sel_tag == key);
      tgt     = hit ? tgt_a[idx] : '0;
      ctr     = hit ? ctr_a[idx] : '0;
      lean_taken = hit && ctr[CTR_W-1];
   end

endmodule

// File: rtl/brtgt_upd.sv
module brtgt_upd
   import brtgt_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned CTR_W = 2
) (
   input  logic             upd_valid,
   input  logic             upd_taken,
   input  logic [PC_W-1:0]  upd_target,
   input  logic             cur_hit,
   input  logic             cur_lean,
   input  logic [PC_W-1:0]  cur_tgt,
   input  logic [CTR_W-1:0] cur_ctr,
   output logic             we,
   output logic [PC_W-1:0]  new_tgt,
   output logic [CTR_W-1:0] new_ctr,
   output logic             mispredict
);

   localparam logic [CTR_MAX_W-1:0] TOP  = CTR_MAX_W'((1 << CTR_W) - 1);
   localparam logic [CTR_W-1:0]     WEAK = CTR_W'(1 << (CTR_W - 1));

   upd_kind_e kind;

   always_comb begin
      if (!upd_valid)     kind = UPD_IDLE;
      else if (cur_hit)   kind = UPD_TRAIN;
      else if (upd_taken) kind = UPD_ALLOC;
      else                kind = UPD_IDLE;
   end

   always_comb begin
      we      = (kind != UPD_IDLE);
      new_tgt = cur_tgt;
      new_ctr = cur_ctr;
      unique case (kind)
         UPD_ALLOC: begin
            new_tgt = upd_target;
            new_ctr = WEAK;
         end
         UPD_TRAIN: begin
            new_ctr = CTR_W'(ctr_step(CTR_MAX_W'(cur_ctr), upd_taken, TOP));
            if (upd_taken) new_tgt = upd_target;
         end
         default: ;
      endcase
   end

   always_comb begin
      mispredict = upd_valid &&
                   ((cur_lean != upd_taken) ||
                    (upd_taken && (cur_tgt != upd_target)));
   end

endmodule

// File: rtl/brtgt_table.sv
module brtgt_table #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned OFS_W = 2,
   parameter int unsigned CTR_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   output logic            hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_target,
   output logic [PC_W-1:0] next_pc,
   output logic            mispredict
);

   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned TAG_W   = PC_W - IDX_W - OFS_W;
   localparam int unsigned IDX_LO  = OFS_W;
   localparam int unsigned IDX_HI  = OFS_W + IDX_W - 1;
   localparam logic [PC_W-1:0] STEP = PC_W'(1 << OFS_W);

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("brtgt_table: IDX_W out of range");
   end
   if (PC_W <= IDX_W + OFS_W) begin : g_bad_pc
      $error("brtgt_table: PC_W leaves no tag bits");
   end
   if (CTR_W < 2 || CTR_W > brtgt_pkg::CTR_MAX_W) begin : g_bad_ctr
      $error("brtgt_table: CTR_W out of range");
   end

   logic             vld_a [ENTRIES];
   logic [TAG_W-1:0] tag_a [ENTRIES];
   logic [PC_W-1:0]  tgt_a [ENTRIES];
   logic [CTR_W-1:0] ctr_a [ENTRIES];

   logic [IDX_W-1:0] f_idx, u_idx;
   logic [TAG_W-1:0] f_tag, u_tag;
   logic [OFS_W-1:0] lo_bits_unused;

   assign f_idx = fetch_pc[IDX_HI:IDX_LO];
   assign f_tag = fetch_pc[PC_W-1:IDX_HI+1];
   assign u_idx = upd_pc[IDX_HI:IDX_LO];
   assign u_tag = upd_pc[PC_W-1:IDX_HI+1];
   assign lo_bits_unused = upd_pc[OFS_W-1:0];

   logic [CTR_W-1:0] f_ctr_unused;
   logic             upd_hit, upd_lean;
   logic [PC_W-1:0]  upd_cur_tgt;
   logic [CTR_W-1:0] upd_cur_ctr;

   brtgt_rdport #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .CTR_W(CTR_W)
   ) u_fetch_rd (
      .idx(f_idx), .key(f_tag),
      .vld_a(vld_a), .tag_a(tag_a), .tgt_a(tgt_a), .ctr_a(ctr_a),
      .hit(hit), .lean_taken(pred_taken), .tgt(pred_target), .ctr(f_ctr_unused)
   );

   brtgt_rdport #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .CTR_W(CTR_W)
   ) u_upd_rd (
      .idx(u_idx), .key(u_tag),
      .vld_a(vld_a), .tag_a(tag_a), .tgt_a(tgt_a), .ctr_a(ctr_a),
      .hit(upd_hit), .lean_taken(upd_lean), .tgt(upd_cur_tgt), .ctr(upd_cur_ctr)
   );

   logic             wr_en;
   logic [PC_W-1:0]  wr_tgt;
   logic [CTR_W-1:0] wr_ctr;

   brtgt_upd #(.PC_W(PC_W), .CTR_W(CTR_W)) u_upd (
      .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_target(upd_target),
      .cur_hit(upd_hit), .cur_lean(upd_lean), .cur_tgt(upd_cur_tgt), .cur_ctr(upd_cur_ctr),
      .we(wr_en), .new_tgt(wr_tgt), .new_ctr(wr_ctr), .mispredict(mispredict)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic sel_wr;
      assign sel_wr = wr_en && (u_idx == IDX_W'(i));
      brtgt_slot #(.TAG_W(TAG_W), .PC_W(PC_W), .CTR_W(CTR_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .wr_en(sel_wr),
         .wr_tag(u_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr),
         .vld(vld_a[i]), .tag(tag_a[i]), .tgt(tgt_a[i]), .ctr(ctr_a[i])
      );
   end

   assign next_pc = pred_taken ? pred_target : fetch_pc + STEP;

endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned OFS_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken,
   input logic [PC_W-1:0] upd_target,
   input logic            hit,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_target,
   input logic            mispredict,
   input logic            upd_hit
);

   localparam int unsigned IHI = OFS_W + IDX_W - 1;

   p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> hit);

   p_miss_target_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (pred_target == '0));

   p_alias_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         (fetch_pc[IHI:OFS_W] != $past(upd_pc[IHI:OFS_W]) ||
          fetch_pc[PC_W-1:IHI+1] == $past(upd_pc[PC_W-1:IHI+1]) || !hit));

   p_alloc_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !upd_hit) |=>
         (fetch_pc != $past(upd_pc) ||
          (hit && pred_taken && pred_target == $past(upd_target))));

   p_nt_miss_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && !upd_hit) |=> (fetch_pc != $past(upd_pc) || !hit));

   p_nt_hit_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && upd_hit) |=> (fetch_pc != $past(upd_pc) || hit));

   p_hit_retarget_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && upd_hit) |=>
         (fetch_pc != $past(upd_pc) || (hit && pred_target == $past(upd_target))));

   p_misp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |-> !mispredict);

   p_misp_taken_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !upd_hit) |-> mispredict);

endmodule

bind brtgt_table brtgt_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .upd_valid(upd_valid),
   .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
   .hit(hit), .pred_taken(pred_taken), .pred_target(pred_target),
   .mispredict(mispredict), .upd_hit(upd_hit)
);

// File: tb/brtgt_table_tb.sv
`timescale 1ns/1ps
module brtgt_table_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        hit, pred_taken, mispredict;
   logic [31:0] pred_target, next_pc;

   always #2 clk = ~clk;

   brtgt_table u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
      .hit(hit), .pred_taken(pred_taken), .pred_target(pred_target),
      .next_pc(next_pc), .mispredict(mispredict)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // Behavioural reference: one remembered branch per slot number.
   bit          m_used [64];
   logic [31:0] m_pc   [64];
   logic [31:0] m_tgt  [64];
   int          m_cnt  [64];

   function automatic bit m_hit(input logic [31:0] pc);
      int s = int'(pc[7:2]);
      return m_used[s] && (m_pc[s][31:8] == pc[31:8]);
   endfunction

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                       input bit ut, input logic [31:0] utg, input string rq);
      int fs, us;
      bit fh, fp, uh, up;
      logic [31:0] ftg;
      @(negedge clk);
      fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
      #1;
      fs = int'(fpc[7:2]);
      fh = m_hit(fpc);
      fp = fh && (m_cnt[fs] >= 2);
      ftg = fh ? m_tgt[fs] : 32'h0;
      chk(rq, "hit", {31'b0, hit}, {31'b0, fh});
      chk(rq, "pred_taken", {31'b0, pred_taken}, {31'b0, fp});
      chk(rq, "pred_target", pred_target, ftg);
      chk(rq, "next_pc", next_pc, fp ? ftg : fpc + 32'd4);
      us = int'(upc[7:2]);
      uh = m_hit(upc);
      up = uh && (m_cnt[us] >= 2);
      chk("R9", "mispredict", {31'b0, mispredict},
          {31'b0, uv && ((up != ut) || (ut && m_tgt[us] != utg))});
      if (uv) begin
         if (uh) begin
            if (ut) begin
               m_cnt[us] = (m_cnt[us] < 3) ? m_cnt[us] + 1 : 3;
               m_tgt[us] = utg;
            end else begin
               m_cnt[us] = (m_cnt[us] > 0) ? m_cnt[us] - 1 : 0;
            end
         end else if (ut) begin
            m_used[us] = 1; m_pc[us] = upc; m_tgt[us] = utg; m_cnt[us] = 2;
         end
      end
   endtask

   task automatic look(input logic [31:0] fpc, input string rq);
      step(fpc, 0, 32'h0, 0, 32'h0, rq);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; upd_valid = 1'b0;
      for (int i = 0; i < 64; i++) m_used[i] = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   localparam logic [31:0] A  = 32'h0000_1040;
   localparam logic [31:0] A2 = 32'h0000_1140;   // same slot as A, other tag
   localparam logic [31:0] B  = 32'h0000_2080;

   initial begin
      do_reset();
      // R1: empty after reset
      look(A, "R1"); look(B, "R1"); look(32'h0, "R1");

      // R5 + R9: taken miss allocates, flagged as mispredict
      step(A, 1, A, 1, 32'h0000_8000, "R10");   // same-cycle lookup sees old state
      look(A, "R5"); look(A, "R3");
      // R2: same slot, different tag never hits
      look(A2, "R2");
      // R6: not-taken miss does not allocate
      step(B, 1, B, 0, 32'h0000_9000, "R6");
      look(B, "R6");
      // R7: not-taken hits decrement, saturate, entry kept
      step(A, 1, A, 0, 32'h0, "R7");
      look(A, "R4");
      step(A, 1, A, 0, 32'h0, "R7");
      step(A, 1, A, 0, 32'h0, "R7");
      look(A, "R7");
      // R8: taken hits increment and rewrite the target
      step(A, 1, A, 1, 32'h0000_A000, "R8");
      look(A, "R8");
      step(A, 1, A, 1, 32'h0000_A000, "R8");
      look(A, "R8");
      step(A, 1, A, 1, 32'h0000_A000, "R8");
      step(A, 1, A, 1, 32'h0000_A000, "R8");
      look(A, "R8");
      // R9: taken with a different target
      step(B, 1, A, 1, 32'h0000_B000, "R9");
      look(A, "R9");
      // R5: overwrite an occupant through an alias
      step(A2, 1, A2, 1, 32'h0000_C000, "R5");
      look(A, "R5"); look(A2, "R5");
      // R1: a second reset forgets everything
      do_reset();
      look(A2, "R1");

      // Mixed traffic over a small colliding PC pool
      for (int n = 0; n < 400; n++) begin
         logic [31:0] pool [5];
         pool[0] = A; pool[1] = A2; pool[2] = B; pool[3] = 32'h0000_3000;
         pool[4] = 32'h0001_2080;
         step(pool[$urandom_range(4)], bit'($urandom_range(1)), pool[$urandom_range(4)],
              bit'($urandom_range(1)), {16'h0, 4'h5, 10'($urandom_range(3)), 2'b00}, "R10");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule